// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between one in-order processor and a shared memory that finishes every access in a single step. Stores from the processor are parked in a small age-ordered buffer rather than written straight to memory. Loads search the buffer first and take the value of the youngest parked store to the same address. Only when nothing matches do they read memory. Whenever the memory grants a write slot, one parked store is retired in the background.

A mode input picks the retirement policy. In total-store-order mode the buffer empties strictly first-in first-out. In partial-store-order mode any address may be retired, but for that address the oldest parked store always goes first. By default the oldest entry overall is chosen. A selector input can steer the choice to another buffered address so that reordering can be exercised. A fence request holds the processor stalled until the buffer is empty. A store that meets a full buffer also stalls until an entry has drained.

Top module: `store_buffer`

## Requirements
- R1: After reset the buffer is empty: `mem_wvalid_o`, `stall_o` and `rsp_valid_o` are all 0.
- R2: An accepted store (`req_op_i` = 1) is held in the buffer, and memory is not written while `mem_wgrant_i` stays 0.
- R3: A load (`req_op_i` = 0) is never stalled. Its result appears on `rsp_rdata_o` with `rsp_valid_o` = 1 in the cycle after acceptance, and it equals the data of the youngest buffered store to the same address.
- R4: A load whose address matches no buffer entry returns the memory data read through `mem_raddr_o`/`mem_rdata_i` in the accept cycle.
- R5: With `mode_pso_i` = 0, stores reach memory in exactly the order they were accepted.
- R6: With `mode_pso_i` = 1, the retired entry is the oldest buffered store to `pso_sel_addr_i` when `pso_sel_en_i` = 1 and such an entry exists. Otherwise it is the oldest entry overall. Per address, memory write order always equals acceptance order.
- R7: At most one entry is written to memory per cycle. A write happens only in a cycle where `mem_wvalid_o` = 1 and `mem_wgrant_i` = 1, and `mem_wvalid_o` is 1 exactly while the buffer holds an entry.
- R8: A fence (`req_op_i` = 2) asserts `stall_o` while the buffer holds any entry. It is accepted in the first cycle the buffer is empty and produces no response.
- R9: A store meeting a buffer holding DEPTH entries (default 8) asserts `stall_o`. A drain in that same cycle does not release it. The store is accepted in the first cycle that starts with a free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_pso_i | input | 1 | 0: FIFO drain, 1: per-address drain |
| pso_sel_en_i | input | 1 | Steer per-address drain to `pso_sel_addr_i` |
| pso_sel_addr_i | input | AW | Preferred drain address in per-address mode |
| req_valid_i | input | 1 | Processor request present |
| req_op_i | input | 2 | 0 load, 1 store, 2 fence, 3 no operation |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Store data |
| stall_o | output | 1 | Request not accepted this cycle |
| rsp_valid_o | output | 1 | Load result valid |
| rsp_rdata_o | output | DW | Load result |
| mem_raddr_o | output | AW | Memory read address |
| mem_rdata_i | input | DW | Memory read data, same cycle |
| mem_wvalid_o | output | 1 | Buffer has an entry to write |
| mem_wgrant_i | input | 1 | Memory accepts a write this cycle |
| mem_waddr_o | output | AW | Memory write address |
| mem_wdata_o | output | DW | Memory write data |

## Verification
Loads are issued against a buffer holding several stores to one address, against untouched addresses, and while drains are running. This separates youngest-match forwarding from oldest-match forwarding and from plain memory reads. The drain is tried under a held-low grant, which shows that stores stay out of memory. It is also tried with FIFO mode, with per-address mode both steered and unsteered, and with a long mixed run of random grants and operations. A golden queue follows every accepted store, so a write taken from the wrong slot or in the wrong order shows up as a mismatch. A full buffer and a fence both stall, and each is released by granting drains, which exposes off-by-one errors in the release cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FENCE = 2'd2,
    OP_NONE  = 2'd3
  } sb_op_e;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic [IW-1:0] pop_idx_i,
  output logic [AW-1:0] addr_o [DEPTH],
  output logic [DW-1:0] data_o [DEPTH],
  output logic [DEPTH-1:0] valid_o,
  output logic [CW-1:0] count_o
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [CW-1:0] count_q;
  logic [CW-1:0] base_cnt;

  // slot index where a push lands after this cycle's removal
  assign base_cnt = count_q - CW'(pop_i);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [AW-1:0] up_a, nxt_a;
    logic [DW-1:0] up_d, nxt_d;
    if (g < DEPTH - 1) begin : g_up
      assign up_a = addr_q[g+1];
      assign up_d = data_q[g+1];
    end else begin : g_top
      assign up_a = '0;
      assign up_d = '0;
    end
    always_comb begin
      nxt_a = addr_q[g];
      nxt_d = data_q[g];
      if (pop_i && (IW'(g) >= pop_idx_i)) begin
        nxt_a = up_a;
        nxt_d = up_d;
      end
      if (push_i && (base_cnt == CW'(g))) begin
        nxt_a = push_addr_i;
        nxt_d = push_data_i;
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[g] <= '0;
        data_q[g] <= '0;
      end else begin
        addr_q[g] <= nxt_a;
        data_q[g] <= nxt_d;
      end
    end
    assign addr_o[g]  = addr_q[g];
    assign data_o[g]  = data_q[g];
    assign valid_o[g] = (CW'(g) < count_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_q + CW'(push_i) - CW'(pop_i);
  end

  assign count_o = count_q;

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (count_q < CW'(DEPTH)));
  // R7
  pop_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (CW'(pop_idx_i) < count_q));
  // R7
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (count_q == $past(count_q) - CW'(1)));
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32
) (
  input  logic [AW-1:0]    addr_i [DEPTH],
  input  logic [DW-1:0]    data_i [DEPTH],
  input  logic [DEPTH-1:0] valid_i,
  input  logic [AW-1:0]    look_addr_i,
  output logic             hit_o,
  output logic [DW-1:0]    data_o
);
  // ascending scan: the youngest match overwrites older ones
  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid_i[i] && (addr_i[i] == look_addr_i)) begin
        hit_o  = 1'b1;
        data_o = data_i[i];
      end
    end
  end
endmodule

// File: rtl/sb_drain_sel.sv
module sb_drain_sel #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 8,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic             mode_pso_i,
  input  logic             sel_en_i,
  input  logic [AW-1:0]    sel_addr_i,
  input  logic [AW-1:0]    addr_i [DEPTH],
  input  logic [DEPTH-1:0] valid_i,
  output logic [IW-1:0]    idx_o,
  output logic             found_o
);
  // descending scan: the oldest match wins; head slot otherwise
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (mode_pso_i && sel_en_i && valid_i[i] && (addr_i[i] == sel_addr_i)) begin
        idx_o   = IW'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/store_buffer.sv
module store_buffer
  import sb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_pso_i,
  input  logic          pso_sel_en_i,
  input  logic [AW-1:0] pso_sel_addr_i,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          stall_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] mem_raddr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_wvalid_o,
  input  logic          mem_wgrant_i,
  output logic [AW-1:0] mem_waddr_o,
  output logic [DW-1:0] mem_wdata_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned IW = $clog2(DEPTH);

  logic [AW-1:0]    q_addr [DEPTH];
  logic [DW-1:0]    q_data [DEPTH];
  logic [DEPTH-1:0] q_valid;
  logic [CW-1:0]    q_count;
  logic             q_full, q_empty;
  logic             is_load, is_store, is_fence;
  logic             accept, push, pop;
  logic [IW-1:0]    drain_idx;
  logic             sel_found;
  logic             fwd_hit;
  logic [DW-1:0]    fwd_data;

  assign q_full   = (q_count == CW'(DEPTH));
  assign q_empty  = (q_count == '0);
  assign is_load  = req_valid_i && (sb_op_e'(req_op_i) == OP_LOAD);
  assign is_store = req_valid_i && (sb_op_e'(req_op_i) == OP_STORE);
  assign is_fence = req_valid_i && (sb_op_e'(req_op_i) == OP_FENCE);

  // fullness is judged at cycle start; a same-cycle drain does not release
  assign stall_o = (is_store && q_full) || (is_fence && !q_empty);
  assign accept  = req_valid_i && !stall_o;
  assign push    = accept && is_store;
  assign pop     = !q_empty && mem_wgrant_i;

  sb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (req_addr_i),
    .push_data_i (req_wdata_i),
    .pop_i       (pop),
    .pop_idx_i   (drain_idx),
    .addr_o      (q_addr),
    .data_o      (q_data),
    .valid_o     (q_valid),
    .count_o     (q_count)
  );

  sb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .addr_i      (q_addr),
    .data_i      (q_data),
    .valid_i     (q_valid),
    .look_addr_i (req_addr_i),
    .hit_o       (fwd_hit),
    .data_o      (fwd_data)
  );

  sb_drain_sel #(.DEPTH(DEPTH), .AW(AW)) u_sel (
    .mode_pso_i (mode_pso_i),
    .sel_en_i   (pso_sel_en_i),
    .sel_addr_i (pso_sel_addr_i),
    .addr_i     (q_addr),
    .valid_i    (q_valid),
    .idx_o      (drain_idx),
    .found_o    (sel_found)
  );

  assign mem_raddr_o  = req_addr_i;
  assign mem_wvalid_o = !q_empty;
  assign mem_waddr_o  = q_addr[drain_idx];
  assign mem_wdata_o  = q_data[drain_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= accept && is_load;
      if (accept && is_load) rsp_rdata_o <= fwd_hit ? fwd_data : mem_rdata_i;
    end
  end

  // R8
  fence_drained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_fence && accept) |-> (q_count == '0));
  // R3
  rsp_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(is_load && accept));
  // R7
  no_grant_no_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_wgrant_i && !push) |=> (q_count == $past(q_count)));
  // R5
  tso_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_pso_i && pop) |-> (drain_idx == '0));
  // R6
  pso_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_pso_i && pso_sel_en_i && sel_found && pop) |-> (mem_waddr_o == pso_sel_addr_i));
endmodule

// File: tb/tb_store_buffer.sv
module tb_store_buffer;
  localparam int DEPTH = 8;
  localparam int AW = 8;
  localparam int DW = 32;

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } ent_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_pso_i = 1'b0;
  logic pso_sel_en_i = 1'b0;
  logic [AW-1:0] pso_sel_addr_i = '0;
  logic req_valid_i = 1'b0;
  logic [1:0] req_op_i = 2'd3;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic stall_o, rsp_valid_o, mem_wvalid_o;
  logic [DW-1:0] rsp_rdata_o, mem_wdata_o, mem_rdata_i;
  logic [AW-1:0] mem_raddr_o, mem_waddr_o;
  logic mem_wgrant_i = 1'b0;

  logic [DW-1:0] mem [256];
  ent_t gold [$];
  int total = 0;
  int bad = 0;
  bit pend = 0;
  logic [DW-1:0] pend_val;
  logic [AW-1:0] last_da;
  logic [DW-1:0] last_dd;
  int drains = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_pso_i(mode_pso_i),
    .pso_sel_en_i(pso_sel_en_i), .pso_sel_addr_i(pso_sel_addr_i),
    .req_valid_i(req_valid_i), .req_op_i(req_op_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .stall_o(stall_o), .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o), .mem_raddr_o(mem_raddr_o), .mem_rdata_i(mem_rdata_i),
    .mem_wvalid_o(mem_wvalid_o), .mem_wgrant_i(mem_wgrant_i),
    .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o));

  function automatic logic [DW-1:0] init_val(int a);
    return DW'(a * 3 + 1);
  endfunction

  initial for (int i = 0; i < 256; i++) mem[i] = init_val(i);
  assign mem_rdata_i = mem[mem_raddr_o];
  always @(posedge clk) if (mem_wvalid_o && mem_wgrant_i) mem[mem_waddr_o] <= mem_wdata_o;

  task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor, mid-cycle
  always @(negedge clk) if (rst_ni && !done) begin
    if (pend) begin
      chk(rsp_valid_o == 1'b1, "R3", "rsp_valid", DW'(rsp_valid_o), 1);
      chk(rsp_rdata_o == pend_val, "R3/R4", "load data", rsp_rdata_o, pend_val);
    end else if (rsp_valid_o) begin
      chk(1'b0, "R3", "spurious rsp", 1, 0);
    end
    pend = 0;
    if (req_valid_i && req_op_i == 2'd0 && !stall_o) begin
      logic [DW-1:0] v;
      v = mem[req_addr_i];
      foreach (gold[i]) if (gold[i].a == req_addr_i) v = gold[i].d;
      pend = 1;
      pend_val = v;
    end
    chk(mem_wvalid_o == (gold.size() != 0), "R7", "wvalid vs occupancy",
        DW'(mem_wvalid_o), DW'(gold.size() != 0));
    if (mem_wvalid_o && mem_wgrant_i && gold.size() != 0) begin
      int k;
      k = 0;
      if (mode_pso_i && pso_sel_en_i) begin
        for (int i = gold.size() - 1; i >= 0; i--) if (gold[i].a == pso_sel_addr_i) k = i;
      end
      chk(mem_waddr_o == gold[k].a, mode_pso_i ? "R6" : "R5", "drain addr",
          DW'(mem_waddr_o), DW'(gold[k].a));
      chk(mem_wdata_o == gold[k].d, mode_pso_i ? "R6" : "R5", "drain data",
          mem_wdata_o, gold[k].d);
      last_da = mem_waddr_o;
      last_dd = mem_wdata_o;
      drains++;
      gold.delete(k);
    end
    if (req_valid_i && req_op_i == 2'd1 && !stall_o) begin
      ent_t e;
      e.a = req_addr_i;
      e.d = req_wdata_i;
      gold.push_back(e);
    end
  end

  // drive one request; grant forced on while stalled so progress is made
  task automatic issue(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    req_valid_i = 1'b1;
    req_op_i = op;
    req_addr_i = a;
    req_wdata_i = d;
    @(negedge clk);
    while (stall_o) begin
      @(posedge clk); #1;
      mem_wgrant_i = 1'b1;
      @(negedge clk);
    end
    @(posedge clk); #1;
    req_valid_i = 1'b0;
    req_op_i = 2'd3;
  endtask

  task automatic grant_one();
    mem_wgrant_i = 1'b1;
    @(posedge clk); #1;
    mem_wgrant_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!mem_wvalid_o && !stall_o && !rsp_valid_o, "R1", "reset outputs",
        {29'd0, mem_wvalid_o, stall_o, rsp_valid_o}, 0);
    @(posedge clk); #1;

    // TSO, grant held low
    issue(2'd1, 8'd10, 32'hA000_0001);
    issue(2'd1, 8'd20, 32'hA000_0002);
    issue(2'd1, 8'd10, 32'hA000_0003);
    @(negedge clk);
    chk(mem[10] == init_val(10), "R2", "memory untouched", mem[10], init_val(10));
    @(posedge clk); #1;
    issue(2'd0, 8'd10, '0); // R3 youngest of two
    issue(2'd0, 8'd20, '0); // R3
    issue(2'd0, 8'd55, '0); // R4 memory path
    @(negedge clk);
    chk(drains == 0, "R2", "no drain without grant", DW'(drains), 0);
    @(posedge clk); #1;
    for (int i = 0; i < 5; i++) issue(2'd1, AW'(30 + i), DW'(32'hB000_0000 + i));
    // buffer now full: R9
    req_valid_i = 1'b1; req_op_i = 2'd1; req_addr_i = 8'd40; req_wdata_i = 32'hC000_0000;
    repeat (3) begin
      @(negedge clk);
      chk(stall_o == 1'b1, "R9", "store stalls when full", DW'(stall_o), 1);
      @(posedge clk); #1;
    end
    mem_wgrant_i = 1'b1;
    @(negedge clk);
    chk(stall_o == 1'b1, "R9", "same-cycle drain keeps stall", DW'(stall_o), 1);
    @(posedge clk); #1;
    mem_wgrant_i = 1'b0;
    @(negedge clk);
    chk(stall_o == 1'b0, "R9", "slot freed releases store", DW'(stall_o), 0);
    @(posedge clk); #1;
    req_valid_i = 1'b0; req_op_i = 2'd3;
    // R8 fence
    req_valid_i = 1'b1; req_op_i = 2'd2;
    @(negedge clk);
    chk(stall_o == 1'b1, "R8", "fence stalls while nonempty", DW'(stall_o), 1);
    @(posedge clk); #1;
    req_valid_i = 1'b0; req_op_i = 2'd3;
    issue(2'd2, '0, '0);
    @(negedge clk);
    chk(gold.size() == 0 && !mem_wvalid_o, "R8", "empty after fence",
        DW'(gold.size()), 0);
    chk(!rsp_valid_o, "R8", "fence gives no response", DW'(rsp_valid_o), 0);
    chk(mem[10] == 32'hA000_0003, "R5", "last store to 10 wins", mem[10], 32'hA000_0003);
    @(posedge clk); #1;
    mem_wgrant_i = 1'b0;

    // PSO
    mode_pso_i = 1'b1;
    issue(2'd1, 8'd1, 32'hD000_0001);
    issue(2'd1, 8'd2, 32'hD000_0002);
    issue(2'd1, 8'd1, 32'hD000_0003);
    issue(2'd1, 8'd2, 32'hD000_0004);
    issue(2'd1, 8'd3, 32'hD000_0005);
    pso_sel_en_i = 1'b1; pso_sel_addr_i = 8'd2;
    grant_one();
    @(negedge clk);
    chk(last_da == 8'd2 && last_dd == 32'hD000_0002, "R6", "steered oldest of addr 2",
        last_dd, 32'hD000_0002);
    @(posedge clk); #1;
    pso_sel_addr_i = 8'd3;
    grant_one();
    @(negedge clk);
    chk(last_dd == 32'hD000_0005, "R6", "steered to addr 3", last_dd, 32'hD000_0005);
    @(posedge clk); #1;
    issue(2'd0, 8'd1, '0); // R3 forwarding in PSO
    pso_sel_en_i = 1'b0;
    grant_one();
    @(negedge clk);
    chk(last_dd == 32'hD000_0001, "R6", "default oldest overall", last_dd, 32'hD000_0001);
    @(posedge clk); #1;
    issue(2'd2, '0, '0);
    mem_wgrant_i = 1'b0;

    // mixed random run, both modes
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      mode_pso_i = (n >= 300);
      pso_sel_en_i = ($urandom_range(0, 1) == 1);
      pso_sel_addr_i = AW'($urandom_range(0, 3));
      mem_wgrant_i = ($urandom_range(0, 2) == 0);
      if (r < 5) issue(2'd1, AW'($urandom_range(0, 3)), $urandom);
      else if (r < 9) issue(2'd0, AW'($urandom_range(0, 4)), '0);
      else issue(2'd2, '0, '0);
      mem_wgrant_i = 1'b0;
    end
    issue(2'd2, '0, '0);
    @(negedge clk);
    chk(gold.size() == 0, "R8", "final drain empty", DW'(gold.size()), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule